// File: doc/BRIEF.md
# DisplayPort AUX Request Framer

This block turns one AUX request into the byte sequence that the AUX transmitter sends, and writes that sequence into the transmitter's buffer one byte per cycle. The request is described by a few inputs: native or I2C-over-AUX, read or write, a middle-of-transaction flag, a 20-bit address, a payload length of 0 to `MAX_LEN` bytes, the payload itself and a defer delay. A single `start` pulse captures all of these inputs.

The block first writes the header: the command nibble with the top address bits, then the two lower address bytes, then a length byte if the request carries data. After the header it writes the payload, but only for writes. It holds the total byte count and the scaled start delay on its outputs. When the last byte is in the buffer, it acknowledges the engine's previous done flag. It then waits until the engine reports that done has cleared, and finally fires a one-cycle `go`. While a request is in progress, `busy` is high and any new `start` is ignored.

Top module: `aux_req_framer`

## Requirements
- R1: Byte 0 carries the command in bits 7:4 and address bits 19:16 in bits 3:0. The command is 4'b1000 for a native write and 4'b1001 for a native read. For I2C it is 4'b0000 for a write and 4'b0001 for a read, with bit 2 set when middle-of-transaction is requested.
- R2: Byte 1 is address bits 15:8 and byte 2 is address bits 7:0.
- R3: When the length is nonzero, byte 3 is the length minus one. When the length is zero, no length byte is written.
- R4: For a write with a nonzero length, payload bytes follow the length byte. Byte 4+i is `req_data[8i+7:8i]`. Reads write no payload.
- R5: `wr_bytes` is 3 for a zero-length request and 4 otherwise, plus the length for writes. It holds steady from the cycle after `start` until the next accepted request.
- R6: `start_delay` equals `req_defer` multiplied by 10.
- R7: `buf_we` is high for exactly `wr_bytes` consecutive cycles. `buf_idx` is 0 on the first of them and rises by one on each following one.
- R8: In the cycle after the last byte, `done_ack` pulses for one cycle. `go` is not raised until `eng_done` has been sampled low after that acknowledge.
- R9: `go` is a single-cycle pulse, one per request. `busy` is low in the cycle after `go`.
- R10: A `start` pulse while `busy` is high has no effect on the bytes written, the counts or the number of `go` pulses.
- R11: After reset, `busy`, `buf_we`, `done_ack` and `go` are low, and `wr_bytes` and `start_delay` are 0.
- R12: For native requests the middle-of-transaction flag is ignored. Bit 2 of the command stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request capture pulse |
| req_i2c | input | 1 | 1: I2C-over-AUX, 0: native |
| req_write | input | 1 | 1: write, 0: read |
| req_mot | input | 1 | Middle-of-transaction flag (I2C only) |
| req_addr | input | 20 | Target address |
| req_len | input | $clog2(MAX_LEN+1) | Payload length in bytes, at most MAX_LEN |
| req_data | input | MAX_LEN*8 | Payload, byte i in bits 8i+7:8i |
| req_defer | input | DEFER_W | Defer delay request |
| eng_done | input | 1 | Engine done status |
| busy | output | 1 | Request in progress |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_idx | output | $clog2(MAX_LEN+5) | Buffer write index |
| buf_byte | output | 8 | Byte being written |
| done_ack | output | 1 | Acknowledge of the engine's done flag |
| go | output | 1 | Transmit start pulse |
| wr_bytes | output | $clog2(MAX_LEN+5) | Total bytes to transmit |
| start_delay | output | DEFER_W+4 | Start delay, defer times 10 |

## Verification
If the byte index or the header selection goes wrong, the recorded buffer image shows a misplaced or missing byte during the load burst itself. That image is compared byte by byte against a model built from the request. A wrong count or delay register is visible on `wr_bytes` or `start_delay` from the cycle after `start`. A sequencing fault shows up as a `go` during a load, a missing acknowledge, or a `go` while the engine still reports done. All of these are checked at the `go` cycle of the same request.

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int MAX_LEN = 16,
  parameter int DEFER_W = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int CNT_W  = $clog2(MAX_LEN + 5),
  localparam int DLY_W  = DEFER_W + 4,
  localparam int DATA_W = MAX_LEN * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               req_i2c,
  input  logic               req_write,
  input  logic               req_mot,
  input  logic [19:0]        req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [DEFER_W-1:0] req_defer,
  input  logic               eng_done,
  output logic               busy,
  output logic               buf_we,
  output logic [CNT_W-1:0]   buf_idx,
  output logic [7:0]         buf_byte,
  output logic               done_ack,
  output logic               go,
  output logic [CNT_W-1:0]   wr_bytes,
  output logic [DLY_W-1:0]   start_delay
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ACK, S_WAIT, S_GO} state_t;

  state_t             state;
  logic               i2c_q, wr_q, mot_q;
  logic [19:0]        addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [DATA_W-1:0]  data_q;
  logic [CNT_W-1:0]   idx;

  logic [CNT_W-1:0]   n_next;
  logic [DLY_W-1:0]   dly_next;
  logic [3:0]         cmd;
  logic [CNT_W-1:0]   pidx;
  logic [7:0]         pay_byte;

  assign n_next   = CNT_W'(req_len == '0 ? 3 : 4) + (req_write ? CNT_W'(req_len) : CNT_W'(0));
  assign dly_next = DLY_W'({req_defer, 3'b000}) + DLY_W'({req_defer, 1'b0});

  assign cmd      = {~i2c_q, i2c_q & mot_q, 1'b0, ~wr_q};
  assign pidx     = idx - CNT_W'(4);
  assign pay_byte = 8'(data_q >> {pidx, 3'b000});

  assign busy     = (state != S_IDLE);
  assign buf_we   = (state == S_LOAD);
  assign buf_idx  = idx;
  assign done_ack = (state == S_ACK);
  assign go       = (state == S_GO);

  always_comb begin
    case (idx)
      CNT_W'(0): buf_byte = {cmd, addr_q[19:16]};
      CNT_W'(1): buf_byte = addr_q[15:8];
      CNT_W'(2): buf_byte = addr_q[7:0];
      CNT_W'(3): buf_byte = 8'(len_q) - 8'd1;
      default:   buf_byte = pay_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      i2c_q       <= 1'b0;
      wr_q        <= 1'b0;
      mot_q       <= 1'b0;
      addr_q      <= '0;
      len_q       <= '0;
      data_q      <= '0;
      idx         <= '0;
      wr_bytes    <= '0;
      start_delay <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          i2c_q       <= req_i2c;
          wr_q        <= req_write;
          mot_q       <= req_mot;
          addr_q      <= req_addr;
          len_q       <= req_len;
          data_q      <= req_data;
          idx         <= '0;
          wr_bytes    <= n_next;
          start_delay <= dly_next;
          state       <= S_LOAD;
        end
        S_LOAD: begin
          if (idx == wr_bytes - CNT_W'(1)) state <= S_ACK;
          else idx <= idx + CNT_W'(1);
        end
        S_ACK:  state <= S_WAIT;
        S_WAIT: if (!eng_done) state <= S_GO;
        S_GO:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module aux_req_framer_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             buf_we,
  input logic [CNT_W-1:0] buf_idx,
  input logic             done_ack,
  input logic             go,
  input logic             eng_done,
  input logic [CNT_W-1:0] wr_bytes
);

  // R7
  idx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_we) |-> buf_idx == '0);

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && $past(buf_we)) |-> buf_idx == $past(buf_idx) + CNT_W'(1));

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> buf_idx < wr_bytes);

  // R8
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_we) |-> done_ack);

  // R8
  go_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!$past(eng_done) && !buf_we));

  // R9
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!go && !busy));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr_bytes));

endmodule

bind aux_req_framer aux_req_framer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .buf_we(buf_we), .buf_idx(buf_idx),
  .done_ack(done_ack), .go(go), .eng_done(eng_done), .wr_bytes(wr_bytes)
);

// File: tb/tb_aux_req_framer.sv
module tb_aux_req_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 16;
  localparam int DEFER_W = 8;
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int CNT_W  = $clog2(MAX_LEN + 5);
  localparam int DLY_W  = DEFER_W + 4;
  localparam int DATA_W = MAX_LEN * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_i2c = 1'b0, req_write = 1'b0, req_mot = 1'b0;
  logic [19:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [DEFER_W-1:0] req_defer = '0;
  logic eng_done = 1'b1;
  logic busy, buf_we, done_ack, go;
  logic [CNT_W-1:0] buf_idx, wr_bytes;
  logic [7:0] buf_byte;
  logic [DLY_W-1:0] start_delay;

  aux_req_framer #(.MAX_LEN(MAX_LEN), .DEFER_W(DEFER_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_i2c(req_i2c), .req_write(req_write),
    .req_mot(req_mot), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .req_defer(req_defer), .eng_done(eng_done), .busy(busy), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_byte(buf_byte), .done_ack(done_ack), .go(go),
    .wr_bytes(wr_bytes), .start_delay(start_delay)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int got_n = 0, go_cnt = 0, ack_cnt = 0, idx_bad = 0, go_early = 0;
  logic [7:0] got [0:31];
  int set_cnt = 0, clr_cnt = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (buf_we) begin
      if (buf_idx != CNT_W'(got_n)) idx_bad++;
      if (got_n < 32) got[got_n] = buf_byte;
      got_n++;
    end
    if (done_ack) begin
      ack_cnt++;
      clr_cnt = 1 + int'($urandom % 4);
    end else if (clr_cnt > 0) begin
      clr_cnt--;
      if (clr_cnt == 0) eng_done = 1'b0;
    end
    if (go) begin
      go_cnt++;
      if (eng_done || ack_cnt == 0) go_early++;
      set_cnt = 3;
    end else if (set_cnt > 0) begin
      set_cnt--;
      if (set_cnt == 0) eng_done = 1'b1;
    end
  end

  function automatic logic [7:0] exp_byte(input bit i2c, input bit wr, input bit mot,
      input logic [19:0] a, input int len, input logic [DATA_W-1:0] d, input int k);
    logic [3:0] c;
    c = i2c ? {2'b00, 1'b0, !wr} : {2'b10, 1'b0, !wr};
    if (i2c && mot) c[2] = 1'b1;
    case (k)
      0: return {c, a[19:16]};
      1: return a[15:8];
      2: return a[7:0];
      3: return 8'(len - 1);
      default: return d[(k-4)*8 +: 8];
    endcase
  endfunction

  task automatic do_req(input bit i2c, input bit wr, input bit mot, input logic [19:0] a,
      input int len, input logic [DATA_W-1:0] d, input logic [DEFER_W-1:0] df, input bit poke);
    int exp_n, waited;
    bit ok;
    exp_n = (len == 0 ? 3 : 4) + (wr ? len : 0);
    got_n = 0; go_cnt = 0; ack_cnt = 0; idx_bad = 0; go_early = 0;
    req_i2c = i2c; req_write = wr; req_mot = mot; req_addr = a;
    req_len = LEN_W'(len); req_data = d; req_defer = df;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R5 R6 visible in the cycle after start
    chk(wr_bytes == CNT_W'(exp_n), "R5 count", wr_bytes, exp_n);
    chk(start_delay == DLY_W'(df) * DLY_W'(10), "R6 delay", start_delay, df * 10);
    if (poke) begin
      @(negedge clk);
      req_addr = ~a; req_write = !wr; req_len = LEN_W'(MAX_LEN - len); req_defer = ~df;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (go_cnt == 0 && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    chk(!busy, "R9 busy after go", busy, 0);
    repeat (4) @(negedge clk);
    chk(go_cnt == 1, poke ? "R10 go count" : "R9 go count", go_cnt, 1);
    chk(ack_cnt == 1, "R8 ack count", ack_cnt, 1);
    chk(go_early == 0, "R8 go before done cleared", go_early, 0);
    chk(idx_bad == 0, "R7 index sequence", idx_bad, 0);
    chk(got_n == exp_n, poke ? "R10 byte count" : "R7 byte count", got_n, exp_n);
    chk(wr_bytes == CNT_W'(exp_n), poke ? "R10 count held" : "R5 count held", wr_bytes, exp_n);
    ok = 1'b1;
    for (int k = 0; k < exp_n && k < 32; k++) begin
      logic [7:0] e;
      e = exp_byte(i2c, wr, mot, a, len, d, k);
      if (got[k] !== e) begin
        ok = 1'b0;
        $display("FAIL %s: byte %0d actual %0h expected %0h",
                 k == 0 ? (i2c ? "R1" : "R12") : k < 3 ? "R2" : k == 3 ? "R3" : "R4", k, got[k], e);
      end
    end
    n_chk++;
    if (!ok) n_bad++;
  endtask

  function automatic logic [DATA_W-1:0] rnd_data();
    logic [DATA_W-1:0] v;
    for (int i = 0; i < MAX_LEN / 4; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    while (cyc < 150000) @(negedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    // R11
    chk(!busy && !buf_we && !done_ack && !go, "R11 controls", {busy, buf_we, done_ack, go}, 0);
    chk(wr_bytes == 0 && start_delay == 0, "R11 counts", {wr_bytes, start_delay}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R11 idle", busy, 0);

    do_req(1'b0, 1'b0, 1'b0, 20'hA5C3E, 0, rnd_data(), 8'd7, 1'b0);   // R3 no length byte
    do_req(1'b0, 1'b1, 1'b1, 20'h12345, 0, rnd_data(), 8'd0, 1'b0);   // R12 native, mot set
    do_req(1'b1, 1'b1, 1'b1, 20'hFFFFF, MAX_LEN, rnd_data(), 8'hFF, 1'b0); // R4 full payload
    do_req(1'b1, 1'b0, 1'b1, 20'h00050, 1, rnd_data(), 8'd3, 1'b0);   // R1 I2C read mot
    do_req(1'b0, 1'b1, 1'b0, 20'h80001, 1, rnd_data(), 8'd25, 1'b0);  // R4 one byte
    do_req(1'b0, 1'b0, 1'b1, 20'h00000, MAX_LEN, rnd_data(), 8'd1, 1'b0); // R4 read no payload
    do_req(1'b1, 1'b1, 1'b0, 20'h3C0F0, 5, rnd_data(), 8'd9, 1'b1);   // R10 start while busy
    for (int n = 0; n < 40; n++) begin
      do_req(1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom),
             int'($urandom % (MAX_LEN + 1)), rnd_data(), DEFER_W'($urandom), 1'($urandom % 5 == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule